// File: doc/BRIEF.md
# CPU Fault Status Capture Unit

This unit records fault events from a processor core in a 16-bit sticky status register. It also tells the core whether the program counter and flags should be saved when the core enters the fault handler. Each fault source sends a strobe one clock long. The strobe sets that source's flag. The flag stays set until software clears it by writing a 1 to it.

While any flag is set, the unit holds a fault request toward the core. A new fault that arrives while an earlier one is still being handled adds its own flag and leaves the earlier flags alone, so the request stays asserted. The unit also produces a context-save enable. It is suppressed while the illegal-opcode flag is set, so a run of repeated illegal opcodes saves context only once.

Software reaches the register through a small bus port. The port supports 16-bit word accesses and 8-bit byte accesses. The byte holding the core fault flags sits at the base address. The auxiliary byte sits at the base address plus one.

Top module: `sys_fault_capture`

## Requirements
- R1: After reset, every status bit reads 0, `excReq` is 0 and `pushEn` is 0.
- R2: A strobe sets one status bit, and the bit reads 1 from the cycle after the strobe. The word bit for each input is: `evtStkOvf` bit 15, `evtPcOvf` bit 14, `evtDivZero` bit 13, `evtDivOvf` bit 12, `evtIllegal` bit 11. Auxiliary input `evtAux[i]` sets word bit i.
- R3: Writing a 1 to a status bit clears it from the next cycle. Writing a 0 leaves the bit as it was. If a strobe and a clear hit the same bit in the same cycle, the bit ends up 1.
- R4: `excReq` is 1 exactly when at least one status bit is 1. A strobe that arrives while other bits are set adds its own bit and leaves the others as they were.
- R5: `pushEn` is 1 in the same cycle as any strobe, but only when bit 11 is currently 0. It is 0 when no strobe is present or when bit 11 is set.
- R6: Word bits 10:8 and auxiliary bits at or above LOW_W always read 0. Writes to these bits have no effect.
- R7: A word access at BASE_ADDR reads the full register and writes `busWdata[15:8]` to bits 15:8 and `busWdata[7:0]` to bits 7:0. A byte access uses `busWdata[7:0]` and returns the byte on `rdData[7:0]`, with `rdData[15:8]` = 0. A byte access at BASE_ADDR reaches bits 15:8, and one at BASE_ADDR+1 reaches bits 7:0.
- R8: Any other address (word access other than at BASE_ADDR, byte access outside BASE_ADDR and BASE_ADDR+1) reads 0, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evtStkOvf | input | 1 | Stack pointer overflow strobe |
| evtPcOvf | input | 1 | Program counter overflow strobe |
| evtDivZero | input | 1 | Divide-by-zero strobe |
| evtDivOvf | input | 1 | Divide overflow strobe |
| evtIllegal | input | 1 | Illegal opcode strobe |
| evtAux | input | LOW_W | Auxiliary fault strobes, one per bit |
| busAddr | input | ADDR_W | Bus byte address |
| busWr | input | 1 | Write strobe (write 1 to clear) |
| busWord | input | 1 | 1 = 16-bit access, 0 = byte access |
| busWdata | input | 16 | Write data |
| rdData | output | 16 | Read data (combinational) |
| excReq | output | 1 | Fault request to the core |
| pushEn | output | 1 | Context-save enable for the current strobe |

## Verification
Assertions check several properties on every cycle:
- The reserved bits stay at 0.
- A strobed bit is 1 in the next cycle, even when a clear hits it in the same cycle.
- The register holds its value when there is neither a strobe nor a clear.
- Any strobe raises the request.
- A context save taken for an illegal opcode cannot be followed, one cycle later, by a second one.

Only the bench scenarios can show the rest:
- the bit position of each source;
- the result of every write-one pattern, including how byte and word writes reach each half;
- that unmatched addresses are ignored;
- that the context save comes back once software clears the illegal-opcode flag.

// File: rtl/fault_pkg.sv
package fault_pkg;
  localparam int REG_W  = 16;
  localparam int BIT_SP = 15;
  localparam int BIT_PC = 14;
  localparam int BIT_DZ = 13;
  localparam int BIT_DO = 12;
  localparam int BIT_IL = 11;

  typedef struct packed {
    logic [REG_W-1:0] setMask;
    logic [REG_W-1:0] clrMask;
    logic             selHi;
    logic             selLo;
    logic             wordAcc;
  } faultStrobe_t;
endpackage

// File: rtl/fault_ctrl.sv
module fault_ctrl
  import fault_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 24'hFFE020,
  parameter int LOW_W = 4
) (
  input  logic [4:0]        evtCore,
  input  logic [LOW_W-1:0]  evtAux,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busWord,
  input  logic [15:0]       busWdata,
  input  logic              illActive,
  output faultStrobe_t      strb,
  output logic              pushEn
);
  localparam logic [ADDR_W-1:0] LO_ADDR = BASE_ADDR + 1'b1;
  localparam logic [7:0] AUX_MASK = 8'((16'd1 << LOW_W) - 16'd1);
  localparam logic [REG_W-1:0] IMPL_MASK = {8'hF8, AUX_MASK};

  logic       atBase, atLow, hitHi, hitLo;
  logic [7:0] hiData, auxSet;

  assign atBase = (busAddr == BASE_ADDR);
  assign atLow  = (busAddr == LO_ADDR);
  assign hitHi  = atBase;
  assign hitLo  = busWord ? atBase : atLow;
  assign hiData = busWord ? busWdata[15:8] : busWdata[7:0];

  always_comb begin
    auxSet = '0;
    auxSet[LOW_W-1:0] = evtAux;
  end

  always_comb begin
    strb.selHi   = hitHi;
    strb.selLo   = hitLo;
    strb.wordAcc = busWord;
    strb.setMask = {evtCore, 3'b000, auxSet} & IMPL_MASK;
    strb.clrMask = {(busWr && hitHi) ? hiData : 8'h00,
                    (busWr && hitLo) ? busWdata[7:0] : 8'h00} & IMPL_MASK;
  end

  assign pushEn = (|strb.setMask) && !illActive;
endmodule

// File: rtl/fault_regs.sv
module fault_regs
  import fault_pkg::*;
#(
  parameter int LOW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  faultStrobe_t     strb,
  output logic [15:0]      rdData,
  output logic             excReq,
  output logic             illActive
);
  localparam logic [7:0] AUX_MASK = 8'((16'd1 << LOW_W) - 16'd1);
  localparam logic [REG_W-1:0] IMPL_MASK = {8'hF8, AUX_MASK};

  logic [REG_W-1:0] status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~strb.clrMask) | strb.setMask;
  end

  always_comb begin
    if (strb.wordAcc && strb.selHi) rdData = status;
    else if (strb.selHi)            rdData = {8'h00, status[15:8]};
    else if (strb.selLo)            rdData = {8'h00, status[7:0]};
    else                            rdData = '0;
  end

  assign excReq    = |status;
  assign illActive = status[BIT_IL];

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~IMPL_MASK) == '0); // R6
  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.setMask != '0) |=> ((status & $past(strb.setMask)) == $past(strb.setMask))); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.setMask == '0 && strb.clrMask == '0) |=> $stable(status)); // R3
endmodule

// File: rtl/sys_fault_capture.sv
module sys_fault_capture
  import fault_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 24'hFFE020,
  parameter int LOW_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evtStkOvf,
  input  logic              evtPcOvf,
  input  logic              evtDivZero,
  input  logic              evtDivOvf,
  input  logic              evtIllegal,
  input  logic [LOW_W-1:0]  evtAux,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busWord,
  input  logic [15:0]       busWdata,
  output logic [15:0]       rdData,
  output logic              excReq,
  output logic              pushEn
);
  faultStrobe_t strb;
  logic         illActive;
  logic [4:0]   evtCore;

  assign evtCore = {evtStkOvf, evtPcOvf, evtDivZero, evtDivOvf, evtIllegal};

  fault_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .LOW_W(LOW_W)) uCtrl (
    .evtCore(evtCore), .evtAux(evtAux), .busAddr(busAddr), .busWr(busWr),
    .busWord(busWord), .busWdata(busWdata), .illActive(illActive),
    .strb(strb), .pushEn(pushEn)
  );

  fault_regs #(.LOW_W(LOW_W)) uRegs (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .rdData(rdData), .excReq(excReq), .illActive(illActive)
  );

  AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (|{evtCore, evtAux}) |=> excReq); // R4
  AST_PUSH_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (pushEn && evtIllegal) |=> !pushEn); // R5
endmodule

// File: tb/sim_sys_fault_capture.sv
`timescale 1ns/1ps
module sim_sys_fault_capture;
  localparam logic [23:0] BASE = 24'hFFE020;
  localparam logic [15:0] IMPL = 16'hF80F;

  logic clk = 0, rst_n = 0;
  logic [4:0] core = '0;
  logic [3:0] aux = '0;
  logic [23:0] addr = '0;
  logic wr = 0, word = 0;
  logic [15:0] wdata = '0;
  logic [15:0] rdData;
  logic excReq, pushEn;
  logic [15:0] model = '0;
  int total = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sys_fault_capture u0 (
    .clk(clk), .rst_n(rst_n), .evtStkOvf(core[4]), .evtPcOvf(core[3]),
    .evtDivZero(core[2]), .evtDivOvf(core[1]), .evtIllegal(core[0]),
    .evtAux(aux), .busAddr(addr), .busWr(wr), .busWord(word),
    .busWdata(wdata), .rdData(rdData), .excReq(excReq), .pushEn(pushEn)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] clrOf(input bit w, input logic [23:0] a, input logic [15:0] d);
    logic [15:0] m = '0;
    if (w && a == BASE) m = d;
    else if (!w && a == BASE) m = {d[7:0], 8'h00};
    else if (!w && a == BASE + 24'd1) m = {8'h00, d[7:0]};
    return m & IMPL;
  endfunction

  // one cycle: strobes and optional write, then registered-state checks
  task automatic cyc(input logic [4:0] c, input logic [3:0] x, input bit w,
                     input bit wd, input logic [23:0] a, input logic [15:0] d, input string req);
    logic [15:0] setM;
    @(negedge clk);
    core = c; aux = x; wr = w; word = wd; addr = a; wdata = d;
    #1;
    setM = {c, 3'b000, 4'h0, x};
    check(pushEn == ((setM != 0) && !model[11]), {req, " R5 pushEn"}, {15'd0, pushEn},
          {15'd0, (setM != 0) && !model[11]});
    @(posedge clk);
    model = (model & ~(w ? clrOf(wd, a, d) : 16'h0)) | setM;
    #1;
    core = '0; aux = '0; wr = 0;
    word = 1; addr = BASE;
    #1;
    check(rdData == model, {req, " word"}, rdData, model);
    check(excReq == (model != 0), {req, " R4 excReq"}, {15'd0, excReq}, {15'd0, model != 0});
  endtask

  task automatic rd(input bit wd, input logic [23:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    word = wd; addr = a; wr = 0;
    #1;
    check(rdData == exp, req, rdData, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rd(1, BASE, 16'h0, "R1 reset status");
    check(excReq == 0 && pushEn == 0, "R1 reset outputs", {14'd0, excReq, pushEn}, 16'h0);
    @(negedge clk); rst_n = 1;

    // R2: each source alone, then cleared by word write (R3)
    for (int i = 0; i < 5; i++) begin
      cyc(5'(1 << i), 4'h0, 0, 1, BASE, 16'h0, "R2 core source");
      check(model[11 + i] == 1, "R2 core bit position", model, 16'(1 << (11 + i)));
      cyc('0, '0, 1, 1, BASE, 16'(1 << (11 + i)), "R3 word clear");
    end
    for (int i = 0; i < 4; i++) begin
      cyc('0, 4'(1 << i), 0, 1, BASE, 16'h0, "R2 aux source");
      cyc('0, '0, 1, 0, BASE + 24'd1, 16'(1 << i), "R3 byte clear low");
    end

    // R5 push once on illegal, nested faults (R4)
    cyc(5'b00001, '0, 0, 1, BASE, 0, "R5 first illegal");
    cyc(5'b00001, '0, 0, 1, BASE, 0, "R5 second illegal");
    cyc(5'b00100, '0, 0, 1, BASE, 0, "R4 nested divzero");
    cyc('0, 4'h2, 0, 1, BASE, 0, "R4 nested aux");
    cyc('0, '0, 1, 0, BASE, 16'h0008, "R3 clear illegal only");
    cyc(5'b10000, '0, 0, 1, BASE, 0, "R5 push restored");
    cyc('0, '0, 1, 1, BASE, 16'hFFFF, "R3 clear all");

    // R3/R6: sweep every byte pattern against a full register
    for (int p = 0; p < 256; p++) begin
      cyc(5'h1F, 4'hF, 0, 1, BASE, 0, "R2 fill");
      cyc('0, '0, 1, 0, BASE, 16'(p), "R6 R3 high byte sweep");
    end
    for (int p = 0; p < 256; p++) begin
      cyc(5'h1F, 4'hF, 0, 1, BASE, 0, "R2 fill");
      cyc('0, '0, 1, 0, BASE + 24'd1, 16'(p), "R6 R3 low byte sweep");
    end
    for (int p = 0; p < 256; p++) begin
      cyc(5'h1F, 4'hF, 0, 1, BASE, 0, "R2 fill");
      cyc('0, '0, 1, 1, BASE, {8'(p), 8'(255 - p)}, "R7 R3 word sweep");
    end

    // R3 set wins over same-cycle clear
    cyc(5'h1F, 4'hF, 0, 1, BASE, 0, "R2 fill");
    cyc(5'b10000, 4'h1, 1, 1, BASE, 16'hFFFF, "R3 set wins");
    check(model == 16'h8001, "R3 set wins value", model, 16'h8001);

    // R7 byte reads, R8 unmatched addresses
    cyc(5'h1F, 4'hF, 0, 1, BASE, 0, "R2 fill");
    rd(0, BASE, 16'h00F8, "R7 byte read high");
    rd(0, BASE + 24'd1, 16'h000F, "R7 byte read low");
    rd(0, BASE + 24'd2, 16'h0000, "R8 read unmatched byte");
    rd(1, BASE + 24'd1, 16'h0000, "R8 read unmatched word");
    cyc('0, '0, 1, 1, BASE + 24'd1, 16'hFFFF, "R8 word write off base");
    cyc('0, '0, 1, 0, BASE - 24'd1, 16'hFFFF, "R8 byte write below");
    cyc('0, '0, 1, 0, BASE + 24'd2, 16'hFFFF, "R8 byte write above");
    check(model == 16'hF80F, "R8 status intact", model, 16'hF80F);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule